// File: doc/BRIEF.md
# Fail-First Vector Length Truncation Unit

This unit follows the per-element fault reports of a speculative, fail-first vector load or store and decides how long the vector ends up. A start pulse carries the requested vector length together with two properties of the request: whether its addressing is vector indexed, and whether it runs in vertical-first stepping. Either property makes the request illegal. Such a request is flagged and does not begin.

Once a legal request is running, one response comes back per issued element. Responses arrive in ascending element order. Each response carries the element index and a flag that says the access would fault.

- A fault on element zero is a normal trap: the unit signals that the exception is to be raised.
- A fault on any later element is swallowed. That access is cancelled and the vector length shrinks to the index of the faulting element.
- Once the sequence has ended, every further response is cancelled. This covers any element at or past the current length, including elements already in flight.

A configuration input clamps every legal request to a length of one. That is the minimal compliant behaviour.

All outputs are registered. A response or start applied before a clock edge is reflected on the outputs just after that edge.

Top module: `ffTruncTop`

## Requirements
- R1: After reset, `vlOut` is 0, `doneOut` is 0, and `cancelOut`, `raiseOut` and `illegalOut` are all 0.
- R2: A legal start is one with both `startIndexed` and `startVertical` low. On the edge that samples it, `vlOut` takes `startVl` and `doneOut` drops to 0.
- R3: While running, a faulting response on index 0 pulses `raiseOut` for one cycle and leaves `cancelOut` low. It also sets `doneOut` and leaves `vlOut` unchanged.
- R4: While running, a faulting response on an index n with 1 ≤ n < `vlOut` pulses `cancelOut` and leaves `raiseOut` low. It also sets `vlOut` to n and sets `doneOut`.
- R5: While running, a non-faulting response below `vlOut - 1` produces no pulse. A non-faulting response on index `vlOut - 1` sets `doneOut` and leaves `vlOut` unchanged.
- R6: After `doneOut` is set, or for any index at or above `vlOut`, a response pulses `cancelOut` only. Its fault flag is ignored: no `raiseOut`, no change to `vlOut` or `doneOut`.
- R7: A legal start with `forceVlOne` high loads `vlOut` with 1, whatever `startVl` is.
- R8: A start with `startIndexed` or `startVertical` high pulses `illegalOut` on the next cycle and does not begin a sequence. Responses that follow produce no pulses, `doneOut` stays 0, and `vlOut` keeps its earlier value.

Ports are listed in the order of the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Start pulse for a new fail-first request |
| startVl | input | VL_W | Requested vector length (≥ 1) |
| startIndexed | input | 1 | Request uses vector indexed addressing (illegal) |
| startVertical | input | 1 | Request runs in vertical-first stepping (illegal) |
| forceVlOne | input | 1 | Clamp every legal request to length 1 |
| respValid | input | 1 | An element response is present |
| respIdx | input | VL_W | Element index of the response |
| respFault | input | 1 | The element's access would fault |
| cancelOut | output | 1 | Pulse: cancel this element's access |
| raiseOut | output | 1 | Pulse: raise the exception for element zero |
| illegalOut | output | 1 | Pulse: start request rejected |
| vlOut | output | VL_W | Current (possibly truncated) vector length |
| doneOut | output | 1 | Sequence has finished |

## Verification
The bench builds the unit with `VL_W = 4`. This allows every requested length from 1 to 15 to be swept in full.

For each length, the bench tries:
- a fault at every position,
- no fault at all,
- the length clamp both off and on.

Every faulting run also keeps the fault flag set on all later indices and sends up to two extra in-flight responses past the original length. This exercises the first-fault-only rule and the suppression of trailing elements at every length boundary.

Illegal starts are issued after a completed run, so the check can confirm that the earlier length survives them.

// File: rtl/ffTruncPkg.sv
package ffTruncPkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic truncate;
  } ffStrobe_t;

  // Comparison status from datapath to control
  typedef struct packed {
    logic idxZero;
    logic idxLast;
    logic idxBeyond;
  } ffStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ffState_t;

endpackage

// File: rtl/ffTruncData.sv
module ffTruncData
  import ffTruncPkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  ffStrobe_t       strb,
  input  logic [VL_W-1:0] startVl,
  input  logic            forceVlOne,
  input  logic [VL_W-1:0] respIdx,
  output logic [VL_W-1:0] vlQ,
  output ffStatus_t       status
);

  localparam logic [VL_W-1:0] VL_ONE = VL_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vlQ <= '0;
    end else if (strb.loadStart) begin
      vlQ <= forceVlOne ? VL_ONE : startVl;
    end else if (strb.truncate) begin
      vlQ <= respIdx;
    end
  end

  always_comb begin
    status.idxZero   = (respIdx == '0);
    status.idxLast   = (respIdx == vlQ - VL_ONE);
    status.idxBeyond = (respIdx >= vlQ);
  end

endmodule

// File: rtl/ffTruncCtrl.sv
module ffTruncCtrl
  import ffTruncPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startValid,
  input  logic      startIndexed,
  input  logic      startVertical,
  input  logic      respValid,
  input  logic      respFault,
  input  ffStatus_t status,
  output ffStrobe_t strb,
  output logic      cancelQ,
  output logic      raiseQ,
  output logic      illegalQ,
  output logic      doneQ
);

  ffState_t state;
  logic legalStart;
  logic respLive;

  always_comb begin
    legalStart     = startValid && !startIndexed && !startVertical;
    respLive       = respValid && (state == ST_RUN) && !status.idxBeyond;
    strb           = '0;
    strb.loadStart = legalStart;
    strb.truncate  = !startValid && respLive && respFault && !status.idxZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cancelQ  <= 1'b0;
      raiseQ   <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      cancelQ  <= 1'b0;
      raiseQ   <= 1'b0;
      illegalQ <= 1'b0;
      if (startValid) begin
        if (legalStart) begin
          state <= ST_RUN;
        end else begin
          state    <= ST_IDLE;
          illegalQ <= 1'b1;
        end
      end else if (respValid && state != ST_IDLE) begin
        if (state == ST_FIN || status.idxBeyond) begin
          cancelQ <= 1'b1;
        end else if (respFault) begin
          state <= ST_FIN;
          if (status.idxZero) raiseQ <= 1'b1;
          else                cancelQ <= 1'b1;
        end else if (status.idxLast) begin
          state <= ST_FIN;
        end
      end
    end
  end

  assign doneQ = (state == ST_FIN);

endmodule

// File: rtl/ffTruncTop.sv
module ffTruncTop
  import ffTruncPkg::*;
#(
  parameter int VL_W = 7
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic [VL_W-1:0] startVl,
  input  logic            startIndexed,
  input  logic            startVertical,
  input  logic            forceVlOne,
  input  logic            respValid,
  input  logic [VL_W-1:0] respIdx,
  input  logic            respFault,
  output logic            cancelOut,
  output logic            raiseOut,
  output logic            illegalOut,
  output logic [VL_W-1:0] vlOut,
  output logic            doneOut
);

  ffStrobe_t strb;
  ffStatus_t status;

  ffTruncCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .startValid   (startValid),
    .startIndexed (startIndexed),
    .startVertical(startVertical),
    .respValid    (respValid),
    .respFault    (respFault),
    .status       (status),
    .strb         (strb),
    .cancelQ      (cancelOut),
    .raiseQ       (raiseOut),
    .illegalQ     (illegalOut),
    .doneQ        (doneOut)
  );

  ffTruncData #(.VL_W(VL_W)) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .startVl   (startVl),
    .forceVlOne(forceVlOne),
    .respIdx   (respIdx),
    .vlQ       (vlOut),
    .status    (status)
  );

endmodule

// File: rtl/ffTruncChecker.sv
module ffTruncChecker #(
  parameter int VL_W = 7
) (
  input logic            clk,
  input logic            rstN,
  input logic            startValid,
  input logic            startIndexed,
  input logic            startVertical,
  input logic            forceVlOne,
  input logic            respValid,
  input logic [VL_W-1:0] respIdx,
  input logic            respFault,
  input logic            cancelOut,
  input logic            raiseOut,
  input logic            illegalOut,
  input logic [VL_W-1:0] vlOut,
  input logic            doneOut
);

  // R3: a raise needs a faulting response on element zero one cycle earlier
  assert_raise_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    raiseOut |-> $past(respValid && respFault && respIdx == '0));

  // R4: a cancel and a raise never appear together
  assert_no_both_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(raiseOut && cancelOut));

  // R6: the length only shrinks between starts
  assert_vl_no_grow_R6: assert property (@(posedge clk) disable iff (!rstN)
    !startValid |=> vlOut <= $past(vlOut));

  // R7: a clamped legal start yields a length of one
  assert_force_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    (startValid && !startIndexed && !startVertical && forceVlOne) |=> vlOut == VL_W'(1));

  // R8: an illegal pulse only follows a rejected start
  assert_illegal_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> $past(startValid && (startIndexed || startVertical)));

  // R5: completion is only ever triggered by a response
  assert_done_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneOut) |-> $past(respValid));

endmodule

bind ffTruncTop ffTruncChecker #(.VL_W(VL_W)) u_chk (.*);

// File: tb/ffTruncTop_tb.sv
module ffTruncTop_tb;
  localparam int VL_W = 4;
  localparam int MAXI = (1 << VL_W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 0, startIndexed = 0, startVertical = 0, forceVlOne = 0;
  logic [VL_W-1:0] startVl = '0;
  logic respValid = 0, respFault = 0;
  logic [VL_W-1:0] respIdx = '0;
  logic cancelOut, raiseOut, illegalOut, doneOut;
  logic [VL_W-1:0] vlOut;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  ffTruncTop #(.VL_W(VL_W)) u_dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doStart(input int vl, input bit frc, input bit idx, input bit vert);
    startValid = 1; startVl = VL_W'(vl); forceVlOne = frc;
    startIndexed = idx; startVertical = vert;
    step();
    startValid = 0; startIndexed = 0; startVertical = 0;
  endtask

  task automatic doResp(input int i, input bit f);
    respValid = 1; respIdx = VL_W'(i); respFault = f;
    step();
    respValid = 0; respFault = 0;
  endtask

  initial begin
    repeat (3) step();
    chk("R1 vl", int'(vlOut), 0);
    chk("R1 done", int'(doneOut), 0);
    chk("R1 pulses", int'({cancelOut, raiseOut, illegalOut}), 0);
    rstN = 1;
    step();

    for (int frc = 0; frc < 2; frc++) begin
      for (int vl = 1; vl <= MAXI; vl++) begin
        for (int f = 0; f <= vl; f++) begin
          int cur;
          bit dn;
          int last;
          cur = (frc != 0) ? 1 : vl;
          dn = 0;
          doStart(vl, frc[0], 0, 0);
          chk(frc != 0 ? "R7 load" : "R2 load", int'(vlOut), cur);
          chk("R2 done clear", int'(doneOut), 0);
          last = (vl + 1 > MAXI) ? MAXI : vl + 1;
          for (int i = 0; i <= last; i++) begin
            bit flt;
            int eC, eR;
            flt = (i >= f) && (f < vl);
            eC = 0; eR = 0;
            if (dn || i >= cur) eC = 1;
            else if (flt) begin
              dn = 1;
              if (i == 0) eR = 1;
              else begin eC = 1; cur = i; end
            end else if (i == cur - 1) dn = 1;
            doResp(i, flt);
            chk(dn && eC ? "R6 cancel" : (flt ? "R4 cancel" : "R5 cancel"), int'(cancelOut), eC);
            chk(flt ? "R3 raise" : "R6 raise", int'(raiseOut), eR);
            chk("R4 vl", int'(vlOut), cur);
            chk("R5 done", int'(doneOut), int'(dn));
          end
        end
      end
    end

    // R8: illegal starts after a completed run of length 5
    for (int k = 1; k < 4; k++) begin
      doStart(5, 0, 0, 0);
      for (int i = 0; i < 5; i++) doResp(i, 0);
      chk("R5 final done", int'(doneOut), 1);
      doStart(9, 0, k[0], k[1]);
      chk("R8 illegal", int'(illegalOut), 1);
      chk("R8 vl kept", int'(vlOut), 5);
      chk("R8 done low", int'(doneOut), 0);
      doResp(0, 1);
      chk("R8 no pulse", int'({cancelOut, raiseOut, illegalOut}), 0);
      doResp(7, 0);
      chk("R8 no cancel", int'(cancelOut), 0);
      chk("R8 vl after", int'(vlOut), 5);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule